// File: doc/BRIEF.md
# LPC Host I/O Cycle Engine

This block is the host end of a Low Pin Count bus for I/O reads and I/O writes. A request names a 16-bit I/O address, a direction, a size of one, two or four bytes, and up to four bytes of write data. The block first checks the address against a small set of decode windows. A request that falls outside every enabled window never reaches the bus: it completes at once and reads as all ones.

A request that does hit a window becomes a run of single-byte bus cycles, one per byte, to consecutive addresses. Each cycle has the same frame. The host drives a start nibble with the frame strobe low, then a cycle-type nibble, then the address and, for a write, the data. It then releases the nibble bus. The peripheral answers with a sync nibble and, for a read, with the data byte. A peripheral can stretch the cycle with wait syncs. It can also report an error, or it can stay silent. In the last two cases the host aborts the cycle and uses FFh for that byte.

Read bytes are packed little-endian into the returned word. A single `done` pulse marks the end of the whole request.

Top module: `lpc_io_host`

## Requirements
- R1: During and right after reset, `lframe_n` is 1, `lad_oe` is 0, and `done` and `busy` are 0.
- R2: Each bus cycle starts with one clock of `lframe_n` low and `lad_out` = 0000b. Next comes one type nibble, 0000b for a read or 0010b for a write. Then come four address nibbles, most significant first.
- R3: A write cycle sends its single data byte right after the address, low nibble first.
- R4: `req_size` 00 means 1 byte, 01 means 2 bytes, and 10 or 11 means 4 bytes. An N-byte request produces exactly N bus cycles to `req_addr`, `req_addr`+1, and so on, in ascending order. Byte k of `req_wdata` (bits 8k+7..8k) goes to address+k.
- R5: For a read, byte k of `rdata` holds the byte from address+k. Bytes at k ≥ N read as zero.
- R6: The host keeps `lad_oe` low for the two turnaround clocks after the address or data, through the whole sync phase, and for the two closing turnaround clocks.
- R7: Sync 0101b or 0110b is a wait. Any number of waits in a row simply extends the cycle, and a wait restarts the no-response count.
- R8: Sync 1010b is an error. The host aborts the cycle, and that byte reads as FFh.
- R9: If three consecutive sync-phase samples are not ready, wait or error, the host aborts. An abort holds `lframe_n` low with `lad_out` = 1111b for exactly 4 clocks, and the byte reads as FFh.
- R10: `done` is a single-cycle pulse, one per accepted request. It comes only after the last byte's cycle has ended. `busy` is high from acceptance until `done`.
- R11: Writing `cfg_we` loads the low bound, high bound (both inclusive) and enable of window `cfg_sel`. A request whose start address is in no enabled window raises `done` on the next clock with `rdata` = FFFFFFFFh, and `lframe_n` never falls.
- R12: A `req_valid` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load decode window `cfg_sel` |
| cfg_sel | input | 2 | Window index |
| cfg_en | input | 1 | Window enable value |
| cfg_lo | input | 16 | Window low bound, inclusive |
| cfg_hi | input | 16 | Window high bound, inclusive |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = I/O write, 0 = I/O read |
| req_size | input | 2 | Byte count code |
| req_addr | input | 16 | Start I/O address |
| req_wdata | input | 32 | Write bytes, little-endian |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request complete pulse |
| rdata | output | 32 | Assembled read bytes |
| lframe_n | output | 1 | Frame strobe, active low |
| lad_out | output | 4 | Host nibble bus value |
| lad_oe | output | 1 | Host drives the nibble bus |
| lad_in | input | 4 | Nibble bus as seen from the pins |

## Verification
The hardest situation to reach from the ports is a multi-byte request in which different bytes end in different ways. One example is a ready byte followed by an error byte, then another ready byte, then a silent byte. Each ending must land FFh or real data in the right lane without breaking the address sequence. The bench reaches this with a peripheral model that follows the frame nibble by nibble on the falling edge. A per-byte response code in each stimulus vector tells the model when to send waits, when to answer ready, when to send the error nibble and when to stay silent. A long wait run that outlasts the no-response limit is also in the table, to show that waits never count toward the timeout.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;

  localparam int IO_AW      = 16;
  localparam int DATA_BYTES = 4;
  localparam int DATA_W     = DATA_BYTES * 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CTYP, ST_ADDR, ST_WDAT,
    ST_TAR1, ST_SYNC, ST_RDAT, ST_TAR2, ST_ABRT
  } bus_st_e;

  typedef enum logic [1:0] {SY_READY, SY_WAIT, SY_ERR, SY_BAD} sync_e;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] NIB_ABORT = 4'hF;

  function automatic logic [3:0] ctype_nib(input logic wr);
    return wr ? 4'b0010 : 4'b0000;
  endfunction

  function automatic sync_e classify_sync(input logic [3:0] n);
    case (n)
      4'b0000:          return SY_READY;
      4'b0101, 4'b0110: return SY_WAIT;
      4'b1010:          return SY_ERR;
      default:          return SY_BAD;
    endcase
  endfunction

  // address nibble i, i = 0 is the most significant
  function automatic logic [3:0] addr_nib(input logic [IO_AW-1:0] a, input logic [1:0] i);
    case (i)
      2'd0:    return a[15:12];
      2'd1:    return a[11:8];
      2'd2:    return a[7:4];
      default: return a[3:0];
    endcase
  endfunction

  function automatic logic [2:0] byte_count(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [7:0] pick_byte(input logic [DATA_W-1:0] w, input logic [1:0] i);
    return w[8*i +: 8];
  endfunction

  function automatic logic [DATA_W-1:0] place_byte(input logic [DATA_W-1:0] w,
                                                   input logic [1:0] i,
                                                   input logic [7:0] b);
    logic [DATA_W-1:0] r;
    r = w;
    r[8*i +: 8] = b;
    return r;
  endfunction

endpackage

// File: rtl/lpc_io_decode.sv
module lpc_io_decode
  import lpc_io_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_en,
  input  logic [IO_AW-1:0] cfg_lo,
  input  logic [IO_AW-1:0] cfg_hi,
  input  logic [IO_AW-1:0] addr,
  output logic             hit
);

  logic [NWIN-1:0]  en_q;
  logic [IO_AW-1:0] lo_q [NWIN];
  logic [IO_AW-1:0] hi_q [NWIN];
  logic [NWIN-1:0]  win_hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[w] <= 1'b0;
        lo_q[w] <= '0;
        hi_q[w] <= '0;
      end else if (cfg_we && cfg_sel == SEL_W'(w)) begin
        en_q[w] <= cfg_en;
        lo_q[w] <= cfg_lo;
        hi_q[w] <= cfg_hi;
      end
    end
    assign win_hit[w] = en_q[w] && (addr >= lo_q[w]) && (addr <= hi_q[w]);
  end

  assign hit = |win_hit;

  // R11
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (|en_q));

endmodule

// File: rtl/lpc_byte_cycle.sv
module lpc_byte_cycle
  import lpc_io_pkg::*;
#(
  parameter int SYNC_LIMIT = 3,
  parameter int ABORT_LEN  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             wr,
  input  logic [IO_AW-1:0] addr,
  input  logic [7:0]       wbyte,
  input  logic [3:0]       lad_in,
  output logic             lframe_n,
  output logic [3:0]       lad_out,
  output logic             lad_oe,
  output logic             byte_done,
  output logic [7:0]       rbyte,
  output logic             busy
);

  localparam int CNT_W = $clog2(ABORT_LEN + 4);
  localparam int INV_W = $clog2(SYNC_LIMIT + 1);

  bus_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic [INV_W-1:0] inv;
  logic             wr_q, abort_q;
  logic [IO_AW-1:0] addr_q;
  logic [7:0]       wb_q, rb_q;
  sync_e            sy;

  assign sy = classify_sync(lad_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      inv     <= '0;
      wr_q    <= 1'b0;
      abort_q <= 1'b0;
      addr_q  <= '0;
      wb_q    <= '0;
      rb_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (kick) begin
          st      <= ST_START;
          wr_q    <= wr;
          addr_q  <= addr;
          wb_q    <= wbyte;
          abort_q <= 1'b0;
          rb_q    <= '0;
        end
        ST_START: st <= ST_CTYP;
        ST_CTYP: begin
          st  <= ST_ADDR;
          cnt <= '0;
        end
        ST_ADDR: begin
          if (cnt == CNT_W'(3)) begin
            st  <= wr_q ? ST_WDAT : ST_TAR1;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_WDAT: begin
          if (cnt == CNT_W'(1)) begin
            st  <= ST_TAR1;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_TAR1: begin
          if (cnt == CNT_W'(1)) begin
            st  <= ST_SYNC;
            cnt <= '0;
            inv <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_SYNC: begin
          case (sy)
            SY_READY: begin
              st  <= wr_q ? ST_TAR2 : ST_RDAT;
              cnt <= '0;
            end
            SY_WAIT: inv <= '0;
            SY_ERR: begin
              st      <= ST_ABRT;
              abort_q <= 1'b1;
              cnt     <= '0;
            end
            default: begin
              if (inv == INV_W'(SYNC_LIMIT - 1)) begin
                st      <= ST_ABRT;
                abort_q <= 1'b1;
                cnt     <= '0;
                inv     <= '0;
              end else inv <= inv + 1'b1;
            end
          endcase
        end
        ST_RDAT: begin
          if (cnt == CNT_W'(0)) begin
            rb_q[3:0] <= lad_in;
            cnt       <= cnt + 1'b1;
          end else begin
            rb_q[7:4] <= lad_in;
            st        <= ST_TAR2;
            cnt       <= '0;
          end
        end
        ST_TAR2: begin
          if (cnt == CNT_W'(1)) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_ABRT: begin
          if (cnt == CNT_W'(ABORT_LEN - 1)) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    lframe_n = 1'b1;
    lad_oe   = 1'b0;
    lad_out  = NIB_ABORT;
    case (st)
      ST_START: begin
        lframe_n = 1'b0;
        lad_oe   = 1'b1;
        lad_out  = NIB_START;
      end
      ST_CTYP: begin
        lad_oe  = 1'b1;
        lad_out = ctype_nib(wr_q);
      end
      ST_ADDR: begin
        lad_oe  = 1'b1;
        lad_out = addr_nib(addr_q, cnt[1:0]);
      end
      ST_WDAT: begin
        lad_oe  = 1'b1;
        lad_out = (cnt == CNT_W'(0)) ? wb_q[3:0] : wb_q[7:4];
      end
      ST_ABRT: begin
        lframe_n = 1'b0;
        lad_oe   = 1'b1;
        lad_out  = NIB_ABORT;
      end
      default: ;
    endcase
  end

  assign byte_done = (st == ST_TAR2 && cnt == CNT_W'(1)) ||
                     (st == ST_ABRT && cnt == CNT_W'(ABORT_LEN - 1));
  assign rbyte = abort_q ? 8'hFF : rb_q;
  assign busy  = (st != ST_IDLE);

  // length of the most recent low run of the frame strobe, saturating
  logic [CNT_W-1:0] low_run;
  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (!lframe_n) low_run <= (low_run == '1) ? low_run : low_run + 1'b1;
    else low_run <= '0;
  end

  // R2
  frame_start_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |-> lad_oe);

  // R9
  abort_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lframe_n) |-> (low_run == CNT_W'(1) || low_run == CNT_W'(ABORT_LEN)));

  // R9
  sync_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SYNC) |-> (inv < INV_W'(SYNC_LIMIT)));

  // R6
  sync_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SYNC && sy == SY_WAIT) |=> !lad_oe);

endmodule

// File: rtl/lpc_io_host.sv
module lpc_io_host
  import lpc_io_pkg::*;
#(
  parameter int NWIN       = 4,
  parameter int SYNC_LIMIT = 3,
  parameter int ABORT_LEN  = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [((NWIN > 1) ? $clog2(NWIN) : 1)-1:0] cfg_sel,
  input  logic                                 cfg_en,
  input  logic [15:0]                          cfg_lo,
  input  logic [15:0]                          cfg_hi,
  input  logic                                 req_valid,
  input  logic                                 req_write,
  input  logic [1:0]                           req_size,
  input  logic [15:0]                          req_addr,
  input  logic [31:0]                          req_wdata,
  output logic                                 busy,
  output logic                                 done,
  output logic [31:0]                          rdata,
  output logic                                 lframe_n,
  output logic [3:0]                           lad_out,
  output logic                                 lad_oe,
  input  logic [3:0]                           lad_in
);

  localparam int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int IDX_W = $clog2(DATA_BYTES) + 1;

  logic              busy_q, wr_q, kick_q, done_q;
  logic [IO_AW-1:0]  addr_q;
  logic [DATA_W-1:0] wdata_q, acc_q, rdata_q, merged;
  logic [IDX_W-1:0]  nb_q, idx_q;
  logic              hit, accept, last_byte;
  logic              eng_busy, eng_done;
  logic [7:0]        eng_rbyte;
  logic [IO_AW-1:0]  cur_addr;
  logic [7:0]        cur_wbyte;

  assign accept    = req_valid && !busy_q;
  assign last_byte = (idx_q == nb_q - 1'b1);
  assign cur_addr  = addr_q + IO_AW'(idx_q);
  assign cur_wbyte = pick_byte(wdata_q, idx_q[1:0]);
  assign merged    = place_byte(acc_q, idx_q[1:0], eng_rbyte);

  lpc_io_decode #(.NWIN(NWIN), .SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_en(cfg_en), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .addr(req_addr), .hit(hit)
  );

  lpc_byte_cycle #(.SYNC_LIMIT(SYNC_LIMIT), .ABORT_LEN(ABORT_LEN)) u_cyc (
    .clk(clk), .rst_n(rst_n), .kick(kick_q), .wr(wr_q),
    .addr(cur_addr), .wbyte(cur_wbyte), .lad_in(lad_in),
    .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe),
    .byte_done(eng_done), .rbyte(eng_rbyte), .busy(eng_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      kick_q  <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      acc_q   <= '0;
      rdata_q <= '0;
      nb_q    <= '0;
      idx_q   <= '0;
    end else begin
      kick_q <= 1'b0;
      done_q <= 1'b0;
      if (accept) begin
        if (hit) begin
          busy_q  <= 1'b1;
          kick_q  <= 1'b1;
          wr_q    <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          nb_q    <= IDX_W'(byte_count(req_size));
          idx_q   <= '0;
          acc_q   <= '0;
        end else begin
          done_q  <= 1'b1;
          rdata_q <= '1;
        end
      end else if (busy_q && eng_done) begin
        acc_q <= merged;
        if (last_byte) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          rdata_q <= merged;
        end else begin
          idx_q  <= idx_q + 1'b1;
          kick_q <= 1'b1;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign rdata = rdata_q;

  // R10
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !last_byte) |=> !done_q);

  // R10
  kick_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |-> !eng_busy);

  // R11
  miss_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (!kick_q && done_q));

  // R12
  busy_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req_valid && !eng_done) |=> $stable(addr_q));

endmodule

// File: tb/tb_lpc_io_host.sv
module tb_lpc_io_host;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_en = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_lo = '0, cfg_hi = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, lframe_n, lad_oe;
  logic [31:0] rdata;
  logic [3:0]  lad_out;
  logic [3:0]  lad_in = 4'hF;

  int n_chk = 0, n_bad = 0;
  int done_cnt = 0, start_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_io_host dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .lframe_n(lframe_n),
    .lad_out(lad_out), .lad_oe(lad_oe), .lad_in(lad_in)
  );

  always @(negedge clk) begin
    if (rst_n && done) done_cnt++;
    if (rst_n && !lframe_n && lad_oe && lad_out == 4'h0) start_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // vector: [62] write, [61:60] size, [59:44] addr, [43:12] wdata,
  //         [11:4] per-byte response (0 ready, 1 error, 2 silent), [3:0] waits
  localparam logic [62:0] VEC [9] = '{
    {1'b0, 2'd0, 16'h0060, 32'h0000_0000, 8'h00, 4'd0},
    {1'b1, 2'd0, 16'h0064, 32'h0000_003C, 8'h00, 4'd0},
    {1'b0, 2'd1, 16'h0070, 32'h0000_0000, 8'h00, 4'd2},
    {1'b1, 2'd2, 16'h0080, 32'hDEAD_BEEF, 8'h00, 4'd1},
    {1'b0, 2'd2, 16'h00FE, 32'h0000_0000, 8'h00, 4'd0},
    {1'b0, 2'd1, 16'h0062, 32'h0000_0000, 8'h02, 4'd0},
    {1'b0, 2'd2, 16'h0090, 32'h0000_0000, 8'h84, 4'd0},
    {1'b0, 2'd0, 16'h0061, 32'h0000_0000, 8'h00, 4'd10},
    {1'b1, 2'd1, 16'h00C0, 32'h0000_A55A, 8'h04, 4'd0}
  };

  task automatic cfg_write(input logic [1:0] sel, input logic en,
                           input logic [15:0] lo, input logic [15:0] hi);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_en = en; cfg_lo = lo; cfg_hi = hi;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive_req(input logic wr, input logic [1:0] sz, input logic [15:0] a,
                           input logic [31:0] wd, input bit spam);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    if (spam) begin
      req_addr = 16'h0099; req_write = 1'b1;
      repeat (3) @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // peripheral model for one byte cycle
  task automatic do_byte(input logic wr, input logic [15:0] ea, input logic [7:0] wb,
                         input logic [1:0] rsp, input logic [3:0] nw);
    logic [15:0] a;
    logic [7:0]  d, rv;
    int t;
    rv = ea[7:0] ^ 8'hA5;
    t = 0;
    do begin
      @(negedge clk); t++;
    end while (!(!lframe_n && lad_oe && lad_out == 4'h0) && t < 100);
    chk(t < 100, "R2 start frame", 32'(t), 32'd100);
    chk(done == 1'b0, "R10 no done mid-request", 32'(done), 32'd0);
    @(negedge clk);
    chk(lad_oe && lframe_n && lad_out == (wr ? 4'b0010 : 4'b0000), "R2 type nibble",
        32'(lad_out), 32'(wr ? 4'b0010 : 4'b0000));
    a = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      a = {a[11:0], lad_out};
    end
    chk(a == ea, "R4 address", 32'(a), 32'(ea));
    if (wr) begin
      @(negedge clk); d[3:0] = lad_out;
      @(negedge clk); d[7:4] = lad_out;
      chk(d == wb, "R3 write byte", 32'(d), 32'(wb));
    end
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!lad_oe, "R6 turnaround released", 32'(lad_oe), 32'd0);
    end
    for (int i = 0; i < int'(nw); i++) begin
      @(negedge clk);
      chk(!lad_oe && lframe_n, "R7 wait sync phase", 32'(lad_oe), 32'd0);
      lad_in = i[0] ? 4'b0110 : 4'b0101;
    end
    case (rsp)
      2'd0: begin
        @(negedge clk); lad_in = 4'b0000;
        if (!wr) begin
          @(negedge clk); lad_in = rv[3:0];
          @(negedge clk); lad_in = rv[7:4];
        end
        for (int i = 0; i < 2; i++) begin
          @(negedge clk); lad_in = 4'hF;
          chk(!lad_oe && lframe_n, "R6 closing turnaround", 32'(lad_oe), 32'd0);
        end
      end
      2'd1: begin
        @(negedge clk); lad_in = 4'b1010;
        for (int i = 0; i < 4; i++) begin
          @(negedge clk); lad_in = 4'hF;
          chk(!lframe_n && lad_oe && lad_out == 4'hF, "R8 error abort",
              {27'd0, lframe_n, lad_out}, 32'h0F);
        end
      end
      default: begin
        for (int i = 0; i < 3; i++) begin
          @(negedge clk); lad_in = 4'hF;
          chk(!lad_oe && lframe_n, "R9 silent sync released", 32'(lad_oe), 32'd0);
        end
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          chk(!lframe_n && lad_oe && lad_out == 4'hF, "R9 timeout abort",
              {27'd0, lframe_n, lad_out}, 32'h0F);
        end
      end
    endcase
  endtask

  task automatic run_req(input logic wr, input logic [1:0] sz, input logic [15:0] a,
                         input logic [31:0] wd, input logic [7:0] rsp, input logic [3:0] nw,
                         input bit spam);
    int n, d0, s0, t;
    logic [31:0] exp;
    logic [15:0] ak;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    d0 = done_cnt; s0 = start_cnt;
    exp = '0;
    for (int k = 0; k < n; k++) begin
      ak = a + 16'(k);
      exp[8*k +: 8] = (rsp[2*k +: 2] == 2'd0) ? (ak[7:0] ^ 8'hA5) : 8'hFF;
    end
    fork
      drive_req(wr, sz, a, wd, spam);
      begin
        for (int k = 0; k < n; k++)
          do_byte(wr, a + 16'(k), wd[8*k +: 8], rsp[2*k +: 2], nw);
      end
    join
    t = 0;
    while (!done && t < 20) begin
      @(negedge clk); t++;
    end
    chk(done && lframe_n, "R10 done after last byte", {31'd0, done}, 32'd1);
    if (!wr) chk(rdata == exp, "R5 read assembly", rdata, exp);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1 && !busy, "R10 single done pulse", 32'(done_cnt - d0), 32'd1);
    chk(start_cnt == s0 + n, spam ? "R12 busy request ignored" : "R4 cycle count",
        32'(start_cnt - s0), 32'(n));
  endtask

  task automatic miss_req(input logic [15:0] a);
    int s0;
    s0 = start_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done && !busy && rdata == 32'hFFFF_FFFF, "R11 miss completes all ones",
        rdata, 32'hFFFF_FFFF);
    repeat (8) @(negedge clk);
    chk(start_cnt == s0 && lframe_n, "R11 miss leaves bus idle", 32'(start_cnt - s0), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(lframe_n && !lad_oe && !done && !busy, "R1 reset state",
        {28'd0, lframe_n, lad_oe, done, busy}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lframe_n && !lad_oe && !done && !busy, "R1 after reset",
        {28'd0, lframe_n, lad_oe, done, busy}, 32'h8);

    cfg_write(2'd0, 1'b1, 16'h0060, 16'h00FF);

    for (int v = 0; v < 9; v++)
      run_req(VEC[v][62], VEC[v][61:60], VEC[v][59:44], VEC[v][43:12],
              VEC[v][11:4], VEC[v][3:0], 1'b0);

    // R11 window edges and reprogramming
    miss_req(16'h005F);
    run_req(1'b0, 2'd0, 16'h00FF, 32'h0, 8'h00, 4'd0, 1'b0);
    miss_req(16'h0205);
    cfg_write(2'd1, 1'b1, 16'h0200, 16'h020F);
    run_req(1'b0, 2'd0, 16'h0205, 32'h0, 8'h00, 4'd0, 1'b0);
    cfg_write(2'd1, 1'b0, 16'h0200, 16'h020F);
    miss_req(16'h0205);

    // R12 request held high while busy
    run_req(1'b0, 2'd1, 16'h00A0, 32'h0, 8'h00, 4'd0, 1'b1);

    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule